// File: doc/BRIEF.md
# Burst Synchronous Serial Master

This block is an 8-bit synchronous serial port that always drives the serial clock. A programmable divider turns a slow enable tick into the serial clock. Transmit bits leave on the falling clock edge and receive bits are captured on the rising edge, through one shift register. A single start command runs a burst of any length from 1 to 256 bits. Software chooses, at start, whether the most or the least significant bit goes first.

Every eighth bit, if bits remain, the block pulses a byte-request strobe and parks the clock high. It resumes when the host either writes a new transmit byte or acknowledges the received byte. An acknowledge sends the register on unchanged, so the byte just received goes out again. When the last bit has been captured, the block drops busy, sets a sticky done flag and pulses an interrupt request.

Top module: `sync_burst_shifter`

## Requirements
- R1: After reset, sclk and sdo are 1 and busy, done, irq and byteReq are 0.
- R2: With divider value n (0..127), each serial clock period lasts 4·(n+1) enable ticks: 2·(n+1) ticks low, then 2·(n+1) ticks high. The clock falls only in a cycle that follows an enable tick.
- R3: sdo changes only in the cycle where sclk falls. sdi is captured at the rising sclk edge.
- R4: With msbFirst=1 at start, bit 7 of each byte is sent first and received bits enter at bit 0. With msbFirst=0, bit 0 is sent first and received bits enter at bit 7.
- R5: A start with bitCount=N−1 produces exactly N serial clock pulses, for any N from 1 to 256.
- R6: After each completed group of 8 bits, when more bits remain, byteReq is high for one cycle. sclk then stays high for as long as neither txWrite nor rxRead is given.
- R7: In the byte wait, txWrite loads txData into the shift register and resumes. rxRead resumes with the register unchanged, so the received byte is sent next. The first byte is taken from txData at start.
- R8: rxData equals the received byte, arranged per R4, in the cycle byteReq is high and after a burst whose length is a multiple of 8.
- R9: When the last bit is captured, busy falls, done rises and irq is high for exactly one cycle. done stays 1 until the next accepted start clears it.
- R10: A start given while busy, including during a byte wait, changes neither the order, the length, the divider nor the data of the running burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Enable tick, one third of the instruction cycle |
| start | input | 1 | Start command pulse |
| msbFirst | input | 1 | Bit order taken at start (1 = MSB first) |
| divSel | input | 7 | Divider value n, taken at start |
| bitCount | input | 8 | Burst length minus one, taken at start |
| txData | input | 8 | Transmit byte |
| txWrite | input | 1 | Load txData and resume after a byte request |
| rxRead | input | 1 | Acknowledge received byte and resume |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| rxData | output | 8 | Shift register contents |
| byteReq | output | 1 | One-cycle byte request strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the block with its default widths: 8-bit shifter, 8-bit count and 7-bit divider. With these widths a 256-bit burst is reachable, which crosses 31 byte waits and the top count value. The enable tick is driven every third clock. Divider values 0 and 2 are used, so the measured clock periods separate the 4·(n+1) rule from an off-by-one in the half-period compare.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2,
    PH_WAIT = 2'd3
  } phase_t;

  typedef struct packed {
    logic load;
    logic drive;
    logic sample;
    logic msbFirst;
  } shiftCtl_t;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             start,
  input  logic             msbFirst,
  input  logic [DIV_W-1:0] divSel,
  input  logic [CNT_W-1:0] bitCount,
  input  logic             txWrite,
  input  logic             rxRead,
  output shiftCtl_t        ctl,
  output logic             sclk,
  output logic             byteReq,
  output logic             busy,
  output logic             done,
  output logic             irq
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int TCK_W = DIV_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  phase_t           phase;
  logic [TCK_W-1:0] tickCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic [IDX_W-1:0] bitIdx;
  logic [DIV_W-1:0] divLatch;
  logic             msbLatch;
  logic [TCK_W-1:0] halfTerm;
  logic             phaseEnd;

  // half period is 2*(n+1) ticks, so terminal count is 2n+1
  assign halfTerm = {divLatch, 1'b1};
  assign phaseEnd = tickEn && (tickCnt == halfTerm);

  always_comb begin
    ctl.load     = ((phase == PH_IDLE) && start) || ((phase == PH_WAIT) && txWrite);
    ctl.drive    = (phase == PH_HIGH) && phaseEnd;
    ctl.sample   = (phase == PH_LOW) && phaseEnd;
    ctl.msbFirst = msbLatch;
  end

  assign sclk = (phase != PH_LOW);
  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      tickCnt  <= '0;
      bitsLeft <= '0;
      bitIdx   <= '0;
      divLatch <= '0;
      msbLatch <= 1'b0;
      byteReq  <= 1'b0;
      done     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      byteReq <= 1'b0;
      irq     <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          msbLatch <= msbFirst;
          divLatch <= divSel;
          bitsLeft <= bitCount;
          bitIdx   <= '0;
          tickCnt  <= '0;
          done     <= 1'b0;
          phase    <= PH_HIGH;
        end
        PH_HIGH: if (tickEn) begin
          if (phaseEnd) begin
            tickCnt <= '0;
            phase   <= PH_LOW;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        PH_LOW: if (tickEn) begin
          if (phaseEnd) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + 1'b1;
            if (bitsLeft == '0) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
              irq   <= 1'b1;
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
              if (bitIdx == LAST_IDX) begin
                phase   <= PH_WAIT;
                byteReq <= 1'b1;
              end else begin
                phase <= PH_HIGH;
              end
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        PH_WAIT: if (txWrite || rxRead) begin
          tickCnt <= '0;
          phase   <= PH_HIGH;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (done && !busy));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(msbLatch) && $stable(divLatch)));
  assert_fall_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> $past(tickEn));
  assert_wait_holds_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT) |=> $stable(bitsLeft));

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtl_t         ctl,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdi,
  output logic [DATA_W-1:0] shiftReg,
  output logic              sdo
);

  logic outBit;

  assign outBit = ctl.msbFirst ? shiftReg[DATA_W-1] : shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b1;
    end else begin
      if (ctl.drive) sdo <= outBit;
      if (ctl.load) begin
        shiftReg <= txData;
      end else if (ctl.sample) begin
        if (ctl.msbFirst) shiftReg <= {shiftReg[DATA_W-2:0], sdi};
        else              shiftReg <= {sdi, shiftReg[DATA_W-1:1]};
      end
    end
  end

  assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sdo != $past(sdo)) |-> $past(ctl.drive));
  assert_no_load_and_shift_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.sample) |-> !$past(ctl.load));

endmodule

// File: rtl/sync_burst_shifter.sv
module sync_burst_shifter
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              start,
  input  logic              msbFirst,
  input  logic [DIV_W-1:0]  divSel,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData,
  output logic              byteReq,
  output logic              busy,
  output logic              done,
  output logic              irq
);

  shiftCtl_t ctl;

  sbs_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .start(start),
    .msbFirst(msbFirst), .divSel(divSel), .bitCount(bitCount),
    .txWrite(txWrite), .rxRead(rxRead), .ctl(ctl), .sclk(sclk),
    .byteReq(byteReq), .busy(busy), .done(done), .irq(irq)
  );

  sbs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txData(txData), .sdi(sdi),
    .shiftReg(rxData), .sdo(sdo)
  );

endmodule

// File: tb/sim_sync_burst_shifter.sv
`timescale 1ns/1ps
module sim_sync_burst_shifter;

  logic clk = 0, rstN = 0, tickEn = 0, start = 0, msbFirst = 0;
  logic [6:0] divSel = 0;
  logic [7:0] bitCount = 0, txData = 0;
  logic txWrite = 0, rxRead = 0, sdi = 0;
  logic sclk, sdo, byteReq, busy, done, irq;
  logic [7:0] rxData;

  int compared = 0, mismatched = 0;
  int bitPos = 0, bitErr = 0, r3Err = 0, irqCnt = 0;
  bit msbCur = 0, finished = 0;
  logic [7:0] txExp [0:32];
  realtime fall0, fall1, rise0;
  logic prevSdo = 1, prevSclk = 1;
  int tickPh = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tickPh <= (tickPh == 2) ? 0 : tickPh + 1;
    tickEn <= (tickPh == 2);
  end

  sync_burst_shifter u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .start(start), .msbFirst(msbFirst),
    .divSel(divSel), .bitCount(bitCount), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .sdi(sdi), .sclk(sclk), .sdo(sdo), .rxData(rxData),
    .byteReq(byteReq), .busy(busy), .done(done), .irq(irq)
  );

  function automatic logic rxBit(int k);
    return ((k * 5 + 3) % 7) < 3;
  endfunction

  function automatic logic [7:0] rxByte(int b, bit msb);
    logic [7:0] r = '0;
    for (int p = 0; p < 8; p++) begin
      if (msb) r[7-p] = rxBit(8*b + p);
      else     r[p]   = rxBit(8*b + p);
    end
    return r;
  endfunction

  // serial-side model: present sdi on falls, record sdo on rises
  always @(negedge sclk) begin
    sdi = rxBit(bitPos);
    if (bitPos == 0) fall0 = $realtime;
    if (bitPos == 1) fall1 = $realtime;
  end
  always @(posedge sclk) begin
    if (bitPos == 0) rise0 = $realtime;
    if (bitPos < 264) begin
      if (sdo !== (msbCur ? txExp[bitPos/8][7-(bitPos%8)] : txExp[bitPos/8][bitPos%8]))
        bitErr++;
    end
    bitPos++;
  end
  always @(negedge clk) begin
    if (irq) irqCnt++;
    if (rstN && (sdo !== prevSdo) && !(prevSclk && !sclk)) r3Err++;
    prevSdo = sdo;
    prevSclk = sclk;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runBurst(int nbits, bit msb, int div, bit useRead, bit poke, int hold);
    int reqs = 0, holdErr = 0, rxErr = 0;
    for (int i = 0; i < 33; i++) txExp[i] = 8'h3C ^ 8'(i * 29);
    bitPos = 0; bitErr = 0; r3Err = 0; irqCnt = 0; msbCur = msb;
    @(negedge clk);
    msbFirst = msb; divSel = 7'(div); bitCount = 8'(nbits - 1);
    txData = txExp[0]; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1 && done === 0, "R9", "busy/done after start", {busy, done}, 2);
    while (busy) begin
      @(negedge clk);
      if (byteReq) begin
        if (rxData !== rxByte(reqs, msb)) rxErr++;
        reqs++;
        if (poke) begin
          msbFirst = !msb; divSel = 7'd5; bitCount = 8'd0; txData = 8'hFF; start = 1;
          @(negedge clk);
          start = 0; msbFirst = msb; divSel = 7'(div);
        end
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          if (sclk !== 1) holdErr++;
        end
        if (useRead) begin
          txExp[reqs] = rxByte(reqs - 1, msb);
          rxRead = 1;
        end else begin
          txData = txExp[reqs];
          txWrite = 1;
        end
        @(negedge clk);
        rxRead = 0; txWrite = 0;
      end
    end
    @(negedge clk);
    check(bitPos == nbits, poke ? "R10" : "R5", "clock pulses", bitPos, nbits);
    check(reqs == (nbits - 1) / 8, "R6", "byte requests", reqs, (nbits - 1) / 8);
    check(bitErr == 0, "R4", "sdo bit errors", bitErr, 0);
    check(r3Err == 0, "R3", "sdo changes off falling edge", r3Err, 0);
    check(rxErr == 0, "R8", "rx byte at request", rxErr, 0);
    check(done === 1 && irqCnt == 1, "R9", "done/irq pulses", irqCnt, 1);
    if (nbits % 8 == 0)
      check(rxData === rxByte(nbits/8 - 1, msb), "R8", "final rxData", rxData, rxByte(nbits/8 - 1, msb));
    if (nbits >= 2) begin
      check(fall1 - fall0 == 60.0 * (div + 1), "R2", "period ns", longint'(fall1 - fall0), 60 * (div + 1));
      check(rise0 - fall0 == 30.0 * (div + 1), "R2", "low half ns", longint'(rise0 - fall0), 30 * (div + 1));
    end
    if (hold > 0) check(holdErr == 0, "R6", "sclk not held in wait", holdErr, 0);
    if (useRead) check(bitErr == 0, "R7", "rxRead resend errors", bitErr, 0);
  endtask

  task automatic testReset();
    check(sclk === 1 && sdo === 1, "R1", "sclk/sdo idle", {sclk, sdo}, 3);
    check(busy === 0 && done === 0 && irq === 0 && byteReq === 0, "R1", "flags idle",
          {busy, done, irq, byteReq}, 0);
  endtask

  task automatic testDoneSticky();
    repeat (20) @(negedge clk);
    check(done === 1 && busy === 0, "R9", "done sticky", {done, busy}, 2);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    runBurst(8, 1, 0, 0, 0, 0);
    testDoneSticky();
    runBurst(16, 0, 2, 0, 0, 0);
    runBurst(1, 1, 1, 0, 0, 0);
    runBurst(24, 1, 0, 1, 1, 40);
    runBurst(13, 0, 0, 0, 0, 5);
    runBurst(256, 0, 0, 0, 0, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule